// File: doc/BRIEF.md
# Edge-Notifying Interrupt Cause Controller

This block holds the interrupt state of a network controller function: a 32-bit cause register, a cause-enable mask, a per-vector extended cause register and its extended mask. Internal event sources raise or lower cause bits through dedicated request ports. A single-op register write port sets or clears bits in each of the four registers. A read port returns the cause register and may clear it.

The block signals an interrupt only on an edge. A notification goes out in the cycle after a masked cause bit moves from inactive to active. Bits that were already pending stay silent when raised again. The active pending set is snapshotted after any same-cycle lower and before the raise.

In per-vector mode, cause bits are routed into the extended register through two allocation entries. One serves the reset-assert cause (bit 30). The other serves every other cause. The block emits a one-cycle pulse carrying the bitmap of newly pending vectors. In single-vector operation the block instead sets an aggregate bit in the extended register. It then pulses a vector-0 notification, pulses a message notification, or raises a level interrupt line, depending on which delivery method is enabled.

Top module: `irq_cause_ctrl`

## Requirements
- R1: After reset all four registers are zero, `vecNotify`, `msgNotify`, `legacyIrq` and `rdValid` are low, and `vecMap` and `extCauseOut` are zero.
- R2: A notification fires only for masked cause bits that become pending in that cycle. Raising a bit that is already pending and masked produces no pulse. All outputs are registered, so each pulse appears one clock after the request and lasts one cycle.
- R3: In per-vector mode (`cfgMsixMode`=1), a newly pending cause bit 30 sets extended bit `cfgRstVecIdx`, but only if `cfgRstVecValid` is 1.
- R4: In per-vector mode, a newly pending cause other than bit 30 sets extended bit `cfgOthVecIdx`, but only if `cfgOthVecValid` is 1.
- R5: In per-vector mode, `vecNotify` pulses with `vecMap` equal to the extended bits that are newly pending (extended cause and extended mask, minus those pending before). There is no pulse when that set is empty. `vecMap` is zero whenever `vecNotify` is low.
- R6: Outside per-vector mode, any newly pending masked cause sets extended bit 31 and copies cause bit 30 into extended bit 30. The delivery is then chosen in this order:
  - if `cfgMsixEn` is 1: a `vecNotify` pulse with `vecMap`=1;
  - else if `cfgMsiEn` is 1: a `msgNotify` pulse;
  - otherwise: `legacyIrq` goes high and stays high.
- R7: A lowering request clears the requested bits. Afterwards, if no masked cause remains pending and per-vector mode is off, extended bit 31 is cleared. In that same case `legacyIrq` drops, but only when both `cfgMsiEn` and `cfgMsixEn` are 0.
- R8: A mask-set write (`regOp`=2) is ANDed with 0x77D4FBFD before it is applied. Enabling a cause that is already pending gives a notification.
- R9: A cause read (`rdEn`) returns the pre-read cause value on `rdData`, with `rdValid` high, one cycle later. It clears all cause bits when any of these holds: `cfgNoSnoopClr` is 1, the mask is zero, or `cfgMsixEn` is 0.
- R10: After a cause read or a cause-clear write (`regOp`=1), the mask bits selected by `cfgAutoMask` are cleared when either condition holds:
  - `cfgNoSnoopClr` is 1;
  - the mask is nonzero and cause bit 31 is still set.
- R11: Extended set (`regOp`=4), extended mask set (5), extended mask clear (6) and extended cause clear (7) data is first ANDed with a filter. The filter is 0x01FFFFFF in per-vector mode and 0xC0000000 otherwise. Cause set is `regOp`=0 and mask clear is `regOp`=3.
- R12: When a lower and a raise reach the same bit in one cycle, the lower is applied first. A bit that was pending and is lowered then raised counts as newly pending.
- R13: When `rdEn` and `regWrEn` are both high in one cycle, the read is performed and the write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtRaiseValid | input | 1 | Internal raise request valid |
| evtRaiseBits | input | 32 | Cause bits to raise |
| evtLowerValid | input | 1 | Internal lower request valid |
| evtLowerBits | input | 32 | Cause bits to lower |
| regWrEn | input | 1 | Register write strobe |
| regOp | input | 3 | Write operation code (see R8, R11) |
| regWrData | input | 32 | Write data |
| rdEn | input | 1 | Cause register read strobe |
| cfgMsixMode | input | 1 | Per-vector cause routing mode |
| cfgMsixEn | input | 1 | Multi-vector message delivery enabled |
| cfgMsiEn | input | 1 | Single message delivery enabled |
| cfgNoSnoopClr | input | 1 | Unconditional clear-on-read and auto-mask |
| cfgAutoMask | input | 32 | Mask bits cleared by auto-masking |
| cfgRstVecValid | input | 1 | Reset-assert cause allocation valid |
| cfgRstVecIdx | input | 5 | Vector for the reset-assert cause |
| cfgOthVecValid | input | 1 | Other-cause allocation valid |
| cfgOthVecIdx | input | 5 | Vector for all other causes |
| rdValid | output | 1 | Read data valid pulse |
| rdData | output | 32 | Cause value before the read |
| vecNotify | output | 1 | Vector notification pulse |
| vecMap | output | 32 | Bitmap of vectors to notify |
| msgNotify | output | 1 | Single message notification pulse |
| legacyIrq | output | 1 | Level interrupt line |
| extCauseOut | output | 32 | Current extended cause register |

## Verification
The edge rule is exercised in several ways:
- repeated raises of a pending bit, which must stay silent;
- enabling a mask bit over an already pending cause, which must notify;
- a lower and a raise on the same bit in one cycle, which separates lower-first ordering from raise-first ordering.

The routing paths are covered one by one: per-vector allocation of the reset-assert cause versus the other causes, the aggregate bit under legacy delivery versus message delivery, and the three conditions for clear-on-read. These distinguish a design that simply ORs bits from one that snapshots the pending set. A long run with seeded random operations and configurations is compared cycle by cycle against a reference model. That run mixes concurrent raises, lowers, reads, writes and mode switches.

// File: rtl/irq_cause_pkg.sv
`timescale 1ns/1ps
package irq_cause_pkg;
  localparam int CW = 32;
  localparam int VIDX_W = $clog2(CW);

  typedef enum logic [2:0] {
    OP_CAUSE_SET    = 3'd0,
    OP_CAUSE_WR     = 3'd1,
    OP_MASK_SET     = 3'd2,
    OP_MASK_CLR     = 3'd3,
    OP_EXT_SET      = 3'd4,
    OP_EXT_MASK_SET = 3'd5,
    OP_EXT_MASK_CLR = 3'd6,
    OP_EXT_CLR      = 3'd7
  } reg_op_e;

  typedef struct packed {
    logic [CW-1:0] raiseCause;
    logic [CW-1:0] lowerCause;
    logic [CW-1:0] raiseMask;
    logic [CW-1:0] lowerMask;
    logic [CW-1:0] raiseExt;
    logic [CW-1:0] lowerExt;
    logic [CW-1:0] raiseExtMask;
    logic [CW-1:0] lowerExtMask;
    logic          anyLower;
    logic          rdCapture;
  } strobe_t;
endpackage

// File: rtl/irq_cause_ctrl_ctl.sv
`timescale 1ns/1ps
module irq_cause_ctrl_ctl
  import irq_cause_pkg::*;
#(
  parameter logic [CW-1:0] MASK_FILTER     = 32'h77D4_FBFD,
  parameter logic [CW-1:0] EXT_MSIX_FILTER = 32'h01FF_FFFF,
  parameter logic [CW-1:0] EXT_LEG_FILTER  = 32'hC000_0000
) (
  input  logic          evtRaiseValid,
  input  logic [CW-1:0] evtRaiseBits,
  input  logic          evtLowerValid,
  input  logic [CW-1:0] evtLowerBits,
  input  logic          regWrEn,
  input  logic [2:0]    regOp,
  input  logic [CW-1:0] regWrData,
  input  logic          rdEn,
  input  logic          cfgMsixMode,
  input  logic          cfgMsixEn,
  input  logic          cfgNoSnoopClr,
  input  logic [CW-1:0] cfgAutoMask,
  input  logic          causeAsserted,
  input  logic          maskAny,
  output strobe_t       stb
);
  logic [CW-1:0] extFilter;
  logic          rdClear;
  logic          rdAutoMask;
  logic          wrAutoMask;
  reg_op_e       op;

  assign extFilter  = cfgMsixMode ? EXT_MSIX_FILTER : EXT_LEG_FILTER;
  assign op         = reg_op_e'(regOp);
  assign rdClear    = cfgNoSnoopClr || !maskAny || !cfgMsixEn;
  // after a clearing read the asserted bit is gone, so only no-snoop mode remains
  assign rdAutoMask = cfgNoSnoopClr || (maskAny && !rdClear && causeAsserted);
  assign wrAutoMask = cfgNoSnoopClr || (maskAny && causeAsserted);

  always_comb begin
    stb = '0;
    if (evtRaiseValid) stb.raiseCause = evtRaiseBits;
    if (evtLowerValid) begin
      stb.lowerCause = evtLowerBits;
      stb.anyLower   = 1'b1;
    end
    if (rdEn) begin
      stb.rdCapture = 1'b1;
      if (rdClear) begin
        stb.lowerCause = '1;
        stb.anyLower   = 1'b1;
      end
      if (rdAutoMask) begin
        stb.lowerMask = cfgAutoMask;
        stb.anyLower  = 1'b1;
      end
    end else if (regWrEn) begin
      unique case (op)
        OP_CAUSE_SET: stb.raiseCause = stb.raiseCause | regWrData;
        OP_CAUSE_WR: begin
          stb.lowerCause = stb.lowerCause | regWrData;
          stb.anyLower   = 1'b1;
          if (wrAutoMask) stb.lowerMask = cfgAutoMask;
        end
        OP_MASK_SET: stb.raiseMask = regWrData & MASK_FILTER;
        OP_MASK_CLR: begin
          stb.lowerMask = regWrData;
          stb.anyLower  = 1'b1;
        end
        OP_EXT_SET:      stb.raiseExt     = regWrData & extFilter;
        OP_EXT_MASK_SET: stb.raiseExtMask = regWrData & extFilter;
        OP_EXT_MASK_CLR: begin
          stb.lowerExtMask = regWrData & extFilter;
          stb.anyLower     = 1'b1;
        end
        OP_EXT_CLR: begin
          stb.lowerExt = regWrData & extFilter;
          stb.anyLower = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irq_cause_ctrl_dp.sv
`timescale 1ns/1ps
module irq_cause_ctrl_dp
  import irq_cause_pkg::*;
#(
  parameter int RST_BIT    = 30,
  parameter int ASSERT_BIT = 31,
  parameter int OTHER_BIT  = 31
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              cfgMsixMode,
  input  logic              cfgMsixEn,
  input  logic              cfgMsiEn,
  input  logic              cfgRstVecValid,
  input  logic [VIDX_W-1:0] cfgRstVecIdx,
  input  logic              cfgOthVecValid,
  input  logic [VIDX_W-1:0] cfgOthVecIdx,
  output logic              causeAsserted,
  output logic              maskAny,
  output logic              rdValid,
  output logic [CW-1:0]     rdData,
  output logic              vecNotify,
  output logic [CW-1:0]     vecMap,
  output logic              msgNotify,
  output logic              legacyIrq,
  output logic [CW-1:0]     extCauseOut
);
  localparam logic [CW-1:0] RST_MASK = {{(CW-1){1'b0}}, 1'b1} << RST_BIT;

  logic [CW-1:0] causeQ, maskQ, extCauseQ, extMaskQ;
  logic [CW-1:0] causeLow, maskLow, extLow, extMaskLow;
  logic [CW-1:0] causeNxt, maskNxt, extNxt, extMaskNxt;
  logic [CW-1:0] midPend, midExtPend, newPend, newExtPend, mapNxt;
  logic          legLow, legNxt, vecNxt, msgNxt;

  always_comb begin
    // lower phase
    causeLow   = causeQ & ~stb.lowerCause;
    maskLow    = maskQ & ~stb.lowerMask;
    extLow     = extCauseQ & ~stb.lowerExt;
    extMaskLow = extMaskQ & ~stb.lowerExtMask;
    legLow     = legacyIrq;
    if (stb.anyLower && ((causeLow & maskLow) == '0) && !cfgMsixMode) begin
      extLow[OTHER_BIT] = 1'b0;
      if (!cfgMsiEn && !cfgMsixEn) legLow = 1'b0;
    end
    // snapshot between lower and raise
    midPend    = causeLow & maskLow;
    midExtPend = extLow & extMaskLow;
    // raise phase
    causeNxt   = causeLow | stb.raiseCause;
    maskNxt    = maskLow | stb.raiseMask;
    extNxt     = extLow | stb.raiseExt;
    extMaskNxt = extMaskLow | stb.raiseExtMask;
    newPend    = causeNxt & maskNxt & ~midPend;
    legNxt     = legLow;
    vecNxt     = 1'b0;
    msgNxt     = 1'b0;
    mapNxt     = '0;
    newExtPend = '0;
    if (cfgMsixMode) begin
      if (((newPend & RST_MASK) != '0) && cfgRstVecValid) extNxt[cfgRstVecIdx] = 1'b1;
      if (((newPend & ~RST_MASK) != '0) && cfgOthVecValid) extNxt[cfgOthVecIdx] = 1'b1;
      newExtPend = extNxt & extMaskNxt & ~midExtPend;
      vecNxt     = (newExtPend != '0);
      mapNxt     = newExtPend;
    end else if (newPend != '0) begin
      extNxt[OTHER_BIT] = 1'b1;
      extNxt[RST_BIT]   = extNxt[RST_BIT] | newPend[RST_BIT];
      if (cfgMsixEn) begin
        vecNxt    = 1'b1;
        mapNxt[0] = 1'b1;
      end else if (cfgMsiEn) begin
        msgNxt = 1'b1;
      end else begin
        legNxt = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      causeQ    <= '0;
      maskQ     <= '0;
      extCauseQ <= '0;
      extMaskQ  <= '0;
      legacyIrq <= 1'b0;
      vecNotify <= 1'b0;
      vecMap    <= '0;
      msgNotify <= 1'b0;
      rdValid   <= 1'b0;
      rdData    <= '0;
    end else begin
      causeQ    <= causeNxt;
      maskQ     <= maskNxt;
      extCauseQ <= extNxt;
      extMaskQ  <= extMaskNxt;
      legacyIrq <= legNxt;
      vecNotify <= vecNxt;
      vecMap    <= mapNxt;
      msgNotify <= msgNxt;
      rdValid   <= stb.rdCapture;
      if (stb.rdCapture) rdData <= causeQ;
    end
  end

  assign causeAsserted = causeQ[ASSERT_BIT];
  assign maskAny       = (maskQ != '0);
  assign extCauseOut   = extCauseQ;
endmodule

// File: rtl/irq_cause_ctrl.sv
`timescale 1ns/1ps
module irq_cause_ctrl
  import irq_cause_pkg::*;
#(
  parameter int RST_BIT    = 30,
  parameter int ASSERT_BIT = 31,
  parameter int OTHER_BIT  = 31,
  parameter logic [31:0] MASK_FILTER     = 32'h77D4_FBFD,
  parameter logic [31:0] EXT_MSIX_FILTER = 32'h01FF_FFFF,
  parameter logic [31:0] EXT_LEG_FILTER  = 32'hC000_0000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        evtRaiseValid,
  input  logic [31:0] evtRaiseBits,
  input  logic        evtLowerValid,
  input  logic [31:0] evtLowerBits,
  input  logic        regWrEn,
  input  logic [2:0]  regOp,
  input  logic [31:0] regWrData,
  input  logic        rdEn,
  input  logic        cfgMsixMode,
  input  logic        cfgMsixEn,
  input  logic        cfgMsiEn,
  input  logic        cfgNoSnoopClr,
  input  logic [31:0] cfgAutoMask,
  input  logic        cfgRstVecValid,
  input  logic [4:0]  cfgRstVecIdx,
  input  logic        cfgOthVecValid,
  input  logic [4:0]  cfgOthVecIdx,
  output logic        rdValid,
  output logic [31:0] rdData,
  output logic        vecNotify,
  output logic [31:0] vecMap,
  output logic        msgNotify,
  output logic        legacyIrq,
  output logic [31:0] extCauseOut
);
  strobe_t stb;
  logic    causeAsserted;
  logic    maskAny;

  irq_cause_ctrl_ctl #(
    .MASK_FILTER    (MASK_FILTER),
    .EXT_MSIX_FILTER(EXT_MSIX_FILTER),
    .EXT_LEG_FILTER (EXT_LEG_FILTER)
  ) u_ctl (
    .evtRaiseValid(evtRaiseValid),
    .evtRaiseBits (evtRaiseBits),
    .evtLowerValid(evtLowerValid),
    .evtLowerBits (evtLowerBits),
    .regWrEn      (regWrEn),
    .regOp        (regOp),
    .regWrData    (regWrData),
    .rdEn         (rdEn),
    .cfgMsixMode  (cfgMsixMode),
    .cfgMsixEn    (cfgMsixEn),
    .cfgNoSnoopClr(cfgNoSnoopClr),
    .cfgAutoMask  (cfgAutoMask),
    .causeAsserted(causeAsserted),
    .maskAny      (maskAny),
    .stb          (stb)
  );

  irq_cause_ctrl_dp #(
    .RST_BIT   (RST_BIT),
    .ASSERT_BIT(ASSERT_BIT),
    .OTHER_BIT (OTHER_BIT)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .stb           (stb),
    .cfgMsixMode   (cfgMsixMode),
    .cfgMsixEn     (cfgMsixEn),
    .cfgMsiEn      (cfgMsiEn),
    .cfgRstVecValid(cfgRstVecValid),
    .cfgRstVecIdx  (cfgRstVecIdx),
    .cfgOthVecValid(cfgOthVecValid),
    .cfgOthVecIdx  (cfgOthVecIdx),
    .causeAsserted (causeAsserted),
    .maskAny       (maskAny),
    .rdValid       (rdValid),
    .rdData        (rdData),
    .vecNotify     (vecNotify),
    .vecMap        (vecMap),
    .msgNotify     (msgNotify),
    .legacyIrq     (legacyIrq),
    .extCauseOut   (extCauseOut)
  );
endmodule

// File: rtl/irq_cause_ctrl_chk.sv
`timescale 1ns/1ps
module irq_cause_ctrl_chk (
  input logic        clk,
  input logic        rstN,
  input logic        rdEn,
  input logic        cfgMsixMode,
  input logic        cfgMsixEn,
  input logic        cfgMsiEn,
  input logic        rdValid,
  input logic        vecNotify,
  input logic [31:0] vecMap,
  input logic        msgNotify,
  input logic        legacyIrq
);
  p_map_nonzero_r5: assert property (@(posedge clk) disable iff (!rstN)
    vecNotify |-> (vecMap != 32'h0));

  p_map_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    !vecNotify |-> (vecMap == 32'h0));

  p_vec_source_r6: assert property (@(posedge clk) disable iff (!rstN)
    vecNotify |-> $past(cfgMsixMode || cfgMsixEn));

  p_msg_source_r6: assert property (@(posedge clk) disable iff (!rstN)
    msgNotify |-> $past(!cfgMsixMode && cfgMsiEn && !cfgMsixEn));

  p_legacy_rise_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(legacyIrq) |-> $past(!cfgMsixMode && !cfgMsiEn && !cfgMsixEn));

  p_one_channel_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(vecNotify && msgNotify));

  p_read_valid_r9: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(rdEn));
endmodule

bind irq_cause_ctrl irq_cause_ctrl_chk u_chk (.*);

// File: tb/irq_cause_ctrl_bench.sv
`timescale 1ns/1ps
module irq_cause_ctrl_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        evtRaiseValid = 0, evtLowerValid = 0, regWrEn = 0, rdEn = 0;
  logic [31:0] evtRaiseBits = 0, evtLowerBits = 0, regWrData = 0;
  logic [2:0]  regOp = 0;
  logic        cfgMsixMode = 0, cfgMsixEn = 0, cfgMsiEn = 0, cfgNoSnoopClr = 0;
  logic [31:0] cfgAutoMask = 0;
  logic        cfgRstVecValid = 0, cfgOthVecValid = 0;
  logic [4:0]  cfgRstVecIdx = 0, cfgOthVecIdx = 0;
  logic        rdValid, vecNotify, msgNotify, legacyIrq;
  logic [31:0] rdData, vecMap, extCauseOut;

  int nChk = 0;
  int nFail = 0;
  bit finished = 0;

  // reference state
  logic [31:0] mC = 0, mM = 0, mE = 0, mEM = 0;
  logic        mLeg = 0;

  always #10 clk = ~clk;

  irq_cause_ctrl u_irq_cause_ctrl (.*);

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    evtRaiseValid = 0; evtLowerValid = 0; regWrEn = 0; rdEn = 0;
    evtRaiseBits = 0; evtLowerBits = 0; regWrData = 0; regOp = 0;
  endtask

  // reference model step derived from the requirements, then compare after the edge
  task automatic tick(input string tag);
    logic [31:0] rC, lC, rM, lM, rE, lE, rEM, lEM, flt;
    logic [31:0] cL, mL, eL, emL, cN, mN, eN, emN, newP, newE, eMap, eRd;
    logic anyL, clr, legN, eVec, eMsg, eRdV;
    rC = 0; lC = 0; rM = 0; lM = 0; rE = 0; lE = 0; rEM = 0; lEM = 0;
    anyL = 0; eRdV = 0; eRd = 0;
    flt = cfgMsixMode ? 32'h01FF_FFFF : 32'hC000_0000;
    if (evtRaiseValid) rC = evtRaiseBits;
    if (evtLowerValid) begin lC = evtLowerBits; anyL = 1; end
    if (rdEn) begin
      eRdV = 1; eRd = mC;
      clr = cfgNoSnoopClr || (mM == 0) || !cfgMsixEn;
      if (clr) begin lC = '1; anyL = 1; end
      if (cfgNoSnoopClr || (mM != 0 && !clr && mC[31])) begin lM = cfgAutoMask; anyL = 1; end
    end else if (regWrEn) begin
      case (regOp)
        3'd0: rC = rC | regWrData;
        3'd1: begin
          lC = lC | regWrData; anyL = 1;
          if (cfgNoSnoopClr || (mM != 0 && mC[31])) lM = cfgAutoMask;
        end
        3'd2: rM = regWrData & 32'h77D4_FBFD;
        3'd3: begin lM = regWrData; anyL = 1; end
        3'd4: rE = regWrData & flt;
        3'd5: rEM = regWrData & flt;
        3'd6: begin lEM = regWrData & flt; anyL = 1; end
        default: begin lE = regWrData & flt; anyL = 1; end
      endcase
    end
    cL = mC & ~lC; mL = mM & ~lM; eL = mE & ~lE; emL = mEM & ~lEM; legN = mLeg;
    if (anyL && (cL & mL) == 0 && !cfgMsixMode) begin
      eL[31] = 0;
      if (!cfgMsiEn && !cfgMsixEn) legN = 0;
    end
    cN = cL | rC; mN = mL | rM; eN = eL | rE; emN = emL | rEM;
    newP = cN & mN & ~(cL & mL);
    eVec = 0; eMsg = 0; eMap = 0;
    if (cfgMsixMode) begin
      if (newP[30] && cfgRstVecValid) eN[cfgRstVecIdx] = 1;
      if ((newP & 32'hBFFF_FFFF) != 0 && cfgOthVecValid) eN[cfgOthVecIdx] = 1;
      newE = eN & emN & ~(eL & emL);
      eMap = newE; eVec = (newE != 0);
    end else if (newP != 0) begin
      eN[31] = 1; eN[30] = eN[30] | newP[30];
      if (cfgMsixEn) begin eVec = 1; eMap = 32'h1; end
      else if (cfgMsiEn) eMsg = 1;
      else legN = 1;
    end
    @(posedge clk); #1;
    chk(tag, "vecNotify", {31'b0, vecNotify}, {31'b0, eVec});
    chk(tag, "vecMap", vecMap, eMap);
    chk(tag, "msgNotify", {31'b0, msgNotify}, {31'b0, eMsg});
    chk(tag, "legacyIrq", {31'b0, legacyIrq}, {31'b0, legN});
    chk(tag, "extCauseOut", extCauseOut, eN);
    chk(tag, "rdValid", {31'b0, rdValid}, {31'b0, eRdV});
    if (eRdV) chk(tag, "rdData", rdData, eRd);
    mC = cN; mM = mN; mE = eN; mEM = emN; mLeg = legN;
    idle();
  endtask

  task automatic wr(input logic [2:0] op, input logic [31:0] d, input string tag);
    regWrEn = 1; regOp = op; regWrData = d; tick(tag);
  endtask
  task automatic raise(input logic [31:0] b, input string tag);
    evtRaiseValid = 1; evtRaiseBits = b; tick(tag);
  endtask
  task automatic rd(input string tag);
    rdEn = 1; tick(tag);
  endtask

  task automatic do_reset();
    idle();
    rstN = 0;
    repeat (3) @(posedge clk);
    #1;
    rstN = 1;
    mC = 0; mM = 0; mE = 0; mEM = 0; mLeg = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    summary();
  end

  initial begin
    int seedDummy;
    do_reset();
    // R1: reset state at the ports
    chk("R1", "vecNotify", {31'b0, vecNotify}, 0);
    chk("R1", "msgNotify", {31'b0, msgNotify}, 0);
    chk("R1", "legacyIrq", {31'b0, legacyIrq}, 0);
    chk("R1", "extCauseOut", extCauseOut, 0);
    chk("R1", "vecMap", vecMap, 0);
    rd("R1");
    chk("R1", "rdData", rdData, 0);

    // per-vector mode
    cfgMsixMode = 1; cfgMsixEn = 1;
    cfgRstVecValid = 1; cfgRstVecIdx = 5; cfgOthVecValid = 1; cfgOthVecIdx = 3;
    wr(3'd5, 32'hFFFF_FFFF, "R11");
    wr(3'd2, 32'h4000_0004, "R8");
    raise(32'h4, "R4");
    chk("R4", "vecMap other", vecMap, 32'h8);
    raise(32'h4, "R2");
    chk("R2", "no repeat notify", {31'b0, vecNotify}, 0);
    raise(32'h4000_0000, "R3");
    chk("R3", "vecMap reset-assert", vecMap, 32'h20);
    raise(32'h2, "R8");
    wr(3'd2, 32'h2, "R8");
    chk("R8", "filtered mask bit", {31'b0, vecNotify}, 0);
    wr(3'd7, 32'h8, "R11");
    raise(32'h100, "R8");
    wr(3'd2, 32'h100, "R8");
    chk("R8", "enable pending", vecMap, 32'h8);
    wr(3'd4, 32'hFFFF_FFFF, "R11");
    chk("R11", "ext filter", extCauseOut, 32'h01FF_FFFF);
    chk("R5", "new ext only", vecMap, 32'h01FF_FFD7);
    wr(3'd7, 32'hFFFF_FFFF, "R11");
    evtLowerValid = 1; evtLowerBits = 32'h4; evtRaiseValid = 1; evtRaiseBits = 32'h4;
    tick("R12");
    chk("R12", "lower then raise", vecMap, 32'h8);

    // single-vector, legacy line
    cfgMsixMode = 0; cfgMsixEn = 0; cfgMsiEn = 0;
    do_reset();
    wr(3'd2, 32'h4000_0004, "R8");
    raise(32'h4, "R6");
    chk("R6", "legacy high", {31'b0, legacyIrq}, 1);
    chk("R6", "aggregate bit", extCauseOut, 32'h8000_0000);
    raise(32'h4000_0000, "R6");
    chk("R6", "reset-assert copy", extCauseOut, 32'hC000_0000);
    wr(3'd1, 32'h4000_0004, "R7");
    chk("R7", "legacy dropped", {31'b0, legacyIrq}, 0);
    chk("R7", "aggregate cleared", extCauseOut, 32'h4000_0000);
    cfgMsiEn = 1;
    raise(32'h4, "R6");
    chk("R6", "message pulse", {31'b0, msgNotify}, 1);
    tick("R2");
    chk("R2", "single pulse", {31'b0, msgNotify}, 0);
    wr(3'd1, 32'h4, "R7");
    cfgMsiEn = 0;

    // cause read
    raise(32'h10, "R9");
    rd("R9");
    chk("R9", "read old", rdData, 32'h10);
    rd("R9");
    chk("R9", "cleared by read", rdData, 0);
    cfgMsixEn = 1;
    raise(32'h10, "R9");
    rd("R9");
    rd("R9");
    chk("R9", "kept on read", rdData, 32'h10);
    wr(3'd3, 32'hFFFF_FFFF, "R9");
    rd("R9");
    rd("R9");
    chk("R9", "zero mask clears", rdData, 0);

    // auto-masking
    do_reset();
    cfgMsixMode = 1; cfgMsixEn = 1; cfgOthVecValid = 1; cfgOthVecIdx = 3;
    cfgAutoMask = 32'h4; cfgNoSnoopClr = 1;
    wr(3'd5, 32'hFFFF_FFFF, "R10");
    wr(3'd2, 32'h4, "R10");
    wr(3'd1, 32'h0, "R10");
    raise(32'h4, "R10");
    chk("R10", "auto-masked no-snoop", {31'b0, vecNotify}, 0);
    cfgNoSnoopClr = 0;
    wr(3'd2, 32'h4, "R8");
    chk("R8", "re-enable pending", vecMap, 32'h8);
    raise(32'h8000_0000, "R10");
    wr(3'd7, 32'hFFFF_FFFF, "R10");
    rd("R10");
    wr(3'd1, 32'h4, "R10");
    raise(32'h4, "R10");
    chk("R10", "auto-masked asserted", {31'b0, vecNotify}, 0);

    // read wins over write
    rdEn = 1; regWrEn = 1; regOp = 3'd2; regWrData = 32'h4;
    tick("R13");
    raise(32'h4, "R13");
    chk("R13", "write discarded", {31'b0, vecNotify}, 0);

    // seeded random mix against the model
    seedDummy = $urandom(32'h00C0_FFEE);
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 31) == 0) begin
        cfgMsixMode = 1'($urandom); cfgMsixEn = 1'($urandom); cfgMsiEn = 1'($urandom);
        cfgNoSnoopClr = ($urandom_range(0, 3) == 0);
        cfgAutoMask = $urandom & $urandom;
        cfgRstVecValid = 1'($urandom); cfgRstVecIdx = 5'($urandom);
        cfgOthVecValid = 1'($urandom); cfgOthVecIdx = 5'($urandom);
      end
      if ($urandom_range(0, 9) < 3) begin
        evtRaiseValid = 1; evtRaiseBits = $urandom & $urandom & $urandom;
      end
      if ($urandom_range(0, 9) < 2) begin
        evtLowerValid = 1; evtLowerBits = $urandom & $urandom;
      end
      if ($urandom_range(0, 9) < 4) begin
        regWrEn = 1; regOp = 3'($urandom); regWrData = $urandom & $urandom;
      end
      if ($urandom_range(0, 9) == 0) rdEn = 1;
      tick("R2");
    end
    summary();
  end
endmodule